// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial bus placed in front of an 8192-byte memory array. It is clocked by a fast system clock and oversamples the bus clock line (SCL) and the data line (SDA). It finds start and stop conditions, shifts bytes in and out, and acknowledges each received byte by pulling SDA low. It holds SDA low through a single output, `sda_pull_o`; outside the block, SDA is an open-drain line with a pull-up.

A master selects the device with a control byte. The upper nibble of this byte is a fixed device type. The next three bits must equal the strap inputs. The last bit selects read or write. A write sends two address bytes and then up to a page of data. A read either continues from the internal pointer, or follows a dummy write that loads the address and then a repeated start. A stop that ends a write starts a self-timed busy period. During this period the device ignores its own address. A write-protect input shields the top quarter of the array.

The bus has no back-pressure. The master paces every bit, and the slave must keep up with each SCL edge. The system clock must therefore run at least about eight times faster than SCL.

Top module: `tws_eeprom_slave`

## Requirements
- R1: A control byte is acknowledged only when bits 7:4 are 1010, bits 3:1 equal strap_i[2:0] and no write cycle is running. Bit 0 selects the direction (1 = read). On a mismatch, the slave gives no acknowledge and ignores all bytes until the next start.
- R2: A start (SDA falls while SCL is high) aborts any transfer and waits for a control byte. A stop (SDA rises while SCL is high) ends the transfer. A data byte cut short by a start is neither stored nor counted as a write.
- R3: SDA is sampled on SCL rising edges. The slave changes its drive only after SCL falls, so the drive is stable while SCL is high.
- R4: Every accepted control byte, every address byte and every write data byte is acknowledged by pulling SDA low during the ninth SCL clock.
- R5: A write sends the address high byte first, then the low byte. The low 5 bits of the high byte and the whole low byte form the 13-bit address. The top 3 bits of the high byte are ignored.
- R6: While wp_i is high, writes to addresses 0x1800–0x1FFF leave the array unchanged but are still acknowledged. While wp_i is low, or for lower addresses, writes take effect.
- R7: During a write, the low 5 address bits advance after each data byte and wrap inside the 32-byte page. Any number of bytes may be written.
- R8: A stop that ends a transfer with at least one complete data byte starts a busy period of WRITE_CYCLES system clocks. During this period control bytes are not acknowledged and the array does not change.
- R9: Read data leaves MSB first, and the slave releases SDA in the ninth clock. If the master acknowledges, the next byte follows, with the address wrapping from 0x1FFF to 0x0000. A master no-acknowledge followed by a stop ends the read.
- R10: The address pointer survives stops. A current-address read returns the byte after the last one read or written.
- R11: After reset, SDA is released and the device is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| strap_i | input | 3 | Device select straps (tie low if unused) |
| wp_i | input | 1 | Write-protect for the top quarter of the array |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |

## Verification
The hardest states to reach from the pins are the ones where the slave must stay silent or must drop work it has partly done. One is the busy window right after a write. The bench reaches it by issuing a new addressed write as soon as the stop is sent, then shows that the memory kept the first value. The other is a data byte cut off by a repeated start. The bench builds it by clocking only four bits before the start, then proves that no write and no busy period followed. Page wrap and the 0x1FFF to 0x0000 read wrap are reached by placing the address next to each boundary.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } tws_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/tws_line_monitor.sv
module tws_line_monitor #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_lvl;
      sda_p  <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_sr[SYNC_STAGES-1];
  assign sda_lvl   = sda_sr[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_p;
  assign scl_fall  = ~scl_lvl & scl_p;
  assign start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/tws_write_timer.sv
module tws_write_timer #(
  parameter int unsigned CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remain <= '0;
    else if (kick && !busy) remain <= LOAD;
    else if (busy)          remain <= remain - ONE;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/tws_store.sv
module tws_store #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int PROT_W = 2
) (
  input  logic              clk,
  input  logic              we_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wp_i,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic guarded;

  // top 1/2^PROT_W of the array is shielded while protect is high
  assign guarded = wp_i && (&addr[ADDR_W-1 -: PROT_W]);

  always_ff @(posedge clk) begin
    if (we_req && !guarded) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/tws_protocol.sv
module tws_protocol
  import tws_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap_i,
  input  logic              busy,
  input  logic [7:0]        rdata,
  output logic [ADDR_W-1:0] ptr,
  output logic              we_req,
  output logic [7:0]        wdata,
  output logic              kick,
  output logic              sda_pull,
  output tws_state_e        state
);
  localparam logic [ADDR_W-1:0] PTR_ONE  = ADDR_W'(1);
  localparam logic [PAGE_W-1:0] PAGE_ONE = PAGE_W'(1);
  localparam logic [3:0]        CNT_ONE  = 4'd1;

  tws_state_e nxt;
  logic [3:0] cnt;
  logic       in_ack, ack_drv, tx_en, mack, pending;
  logic [7:0] sh, tx;
  logic       rx_state, eval, sel_ok;

  assign rx_state = (state == ST_CTRL) || (state == ST_AHI) ||
                    (state == ST_ALO)  || (state == ST_WDAT);
  assign eval     = rx_state && scl_fall && !in_ack && (cnt == 4'd8);
  assign sel_ok   = (sh[7:4] == DEV_TYPE) && (sh[3:1] == strap_i) && !busy;
  assign we_req   = eval && (state == ST_WDAT);
  assign wdata    = sh;
  assign kick     = stop_det && pending;
  assign sda_pull = ack_drv || ((state == ST_RDAT) && tx_en && !tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      cnt     <= '0;
      in_ack  <= 1'b0;
      ack_drv <= 1'b0;
      tx_en   <= 1'b0;
      mack    <= 1'b0;
      pending <= 1'b0;
      sh      <= '0;
      tx      <= '0;
      ptr     <= '0;
    end else if (start_det) begin
      state   <= ST_CTRL;
      cnt     <= '0;
      in_ack  <= 1'b0;
      ack_drv <= 1'b0;
      tx_en   <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      in_ack  <= 1'b0;
      ack_drv <= 1'b0;
      tx_en   <= 1'b0;
      pending <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: ;
        ST_RDAT: begin
          if (scl_rise) begin
            if (cnt < 4'd8) cnt <= cnt + CNT_ONE;
            else if (cnt == 4'd8) begin
              mack <= ~sda_lvl;
              cnt  <= 4'd9;
            end
          end else if (scl_fall) begin
            if (cnt >= 4'd1 && cnt <= 4'd7) tx <= {tx[6:0], 1'b0};
            else if (cnt == 4'd8) begin
              tx_en <= 1'b0;
              ptr   <= ptr + PTR_ONE;
            end else if (cnt == 4'd9) begin
              if (mack) begin
                tx    <= rdata;
                tx_en <= 1'b1;
                cnt   <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end
        default: begin
          if (scl_rise && !in_ack && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda_lvl};
            cnt <= cnt + CNT_ONE;
          end else if (eval) begin
            in_ack <= 1'b1;
            case (state)
              ST_CTRL: begin
                ack_drv <= sel_ok;
                nxt     <= !sel_ok ? ST_IDLE : (sh[0] ? ST_RDAT : ST_AHI);
              end
              ST_AHI: begin
                ptr[ADDR_W-1:8] <= sh[ADDR_W-9:0];
                ack_drv <= 1'b1;
                nxt     <= ST_ALO;
              end
              ST_ALO: begin
                ptr[7:0] <= sh;
                ack_drv  <= 1'b1;
                nxt      <= ST_WDAT;
              end
              default: begin
                ptr     <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_ONE};
                pending <= 1'b1;
                ack_drv <= 1'b1;
                nxt     <= ST_WDAT;
              end
            endcase
          end else if (scl_fall && in_ack) begin
            in_ack  <= 1'b0;
            ack_drv <= 1'b0;
            cnt     <= '0;
            state   <= nxt;
            if (nxt == ST_RDAT) begin
              tx    <= rdata;
              tx_en <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tws_eeprom_slave.sv
module tws_eeprom_slave #(
  parameter int          ADDR_W       = 13,
  parameter int          PAGE_W       = 5,
  parameter int          PROT_W       = 2,
  parameter int unsigned WRITE_CYCLES = 1000000,
  parameter int          SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_pull_o
);
  import tws_pkg::*;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic busy, kick, we_req;
  logic [7:0] wdata, rdata;
  logic [ADDR_W-1:0] ptr;
  tws_state_e state;

  tws_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  tws_protocol #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
    .strap_i(strap_i), .busy(busy), .rdata(rdata), .ptr(ptr),
    .we_req(we_req), .wdata(wdata), .kick(kick), .sda_pull(sda_pull_o),
    .state(state)
  );

  tws_store #(.ADDR_W(ADDR_W), .DATA_W(8), .PROT_W(PROT_W)) u_store (
    .clk(clk), .we_req(we_req), .addr(ptr), .wdata(wdata),
    .wp_i(wp_i), .rdata(rdata)
  );

  tws_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy)
  );
endmodule

// File: rtl/tws_checker.sv
module tws_checker
  import tws_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              sda_pull,
  input logic              busy,
  input logic              start_det,
  input logic              stop_det,
  input logic              we_req,
  input logic [ADDR_W-1:0] ptr,
  input tws_state_e        state
);
  // R3
  pull_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull));

  // R8
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  // R8
  no_busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_req |-> !busy);

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_req |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

  // R2
  start_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_CTRL));

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE));
endmodule

bind tws_eeprom_slave tws_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_pull(sda_pull_o),
  .busy(busy), .start_det(start_det), .stop_det(stop_det),
  .we_req(we_req), .ptr(ptr), .state(state)
);

// File: tb/tb_tws_eeprom_slave.sv
module tb_tws_eeprom_slave;
  localparam int H = 8;
  localparam logic [7:0] CW = 8'hAA;  // 1010 101 0
  localparam logic [7:0] CR = 8'hAB;  // 1010 101 1
  // {wp, addr[15:0], data, expected readback}
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 16'h0005, 8'h3C, 8'h3C},
    {1'b0, 16'h1800, 8'h5A, 8'h5A},
    {1'b1, 16'h1800, 8'hA5, 8'h5A},
    {1'b1, 16'h17FF, 8'h77, 8'h77},
    {1'b0, 16'h1FFF, 8'hC3, 8'hC3},
    {1'b1, 16'hE005, 8'h99, 8'h99}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  tws_eeprom_slave #(.WRITE_CYCLES(400)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_pull_o(sda_pull)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp;
    repeat (H) @(posedge clk);
    #1;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hp; scl_m = 1'b1; hp; sda_m = 1'b0; hp; scl_m = 1'b0; hp;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hp; scl_m = 1'b1; hp; sda_m = 1'b1; hp;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp; scl_m = 1'b1; hp; scl_m = 1'b0; hp;
    end
    sda_m = 1'b1; hp; scl_m = 1'b1; hp;
    ack = ~sda_line;
    scl_m = 1'b0; hp;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b1; hp; b[i] = sda_line; scl_m = 1'b0; hp;
    end
    sda_m = ~give_ack; hp; scl_m = 1'b1; hp; scl_m = 1'b0; hp;
    sda_m = 1'b1; hp;
  endtask

  task automatic addr_phase(input logic [15:0] a, output logic ok);
    logic k0, k1, k2;
    bus_start;
    send_byte(CW, k0); send_byte(a[15:8], k1); send_byte(a[7:0], k2);
    ok = k0 & k1 & k2;
  endtask

  task automatic wait_ready;
    logic k;
    for (int t = 0; t < 40; t++) begin
      bus_start; send_byte(CW, k); bus_stop;
      if (k) break;
    end
  endtask

  task automatic write_one(input logic [15:0] a, input logic [7:0] d, output logic ok);
    logic k0, k1;
    addr_phase(a, k0); send_byte(d, k1); bus_stop;
    ok = k0 & k1;
    wait_ready;
  endtask

  task automatic rand_read(input logic [15:0] a, output logic [7:0] d);
    logic k0, k1;
    addr_phase(a, k0);
    bus_start; send_byte(CR, k1); recv_byte(d, 1'b0); bus_stop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic k, ok;
    logic [7:0] d, d2;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    hp;
    chk("R11 sda released after reset", {31'd0, sda_pull}, 32'd0);

    bus_start; send_byte(CW, k); bus_stop;
    chk("R11 R1 control ack when idle", {31'd0, k}, 32'd1);

    bus_start; send_byte(8'hA2, k);
    chk("R1 strap mismatch nack", {31'd0, k}, 32'd0);
    send_byte(CW, k);
    chk("R1 silent until next start", {31'd0, k}, 32'd0);
    bus_stop;
    bus_start; send_byte(8'hEA, k); bus_stop;
    chk("R1 wrong device type nack", {31'd0, k}, 32'd0);

    // table walk: R4 R5 R6
    for (int v = 0; v < 6; v++) begin
      wp = VEC[v][32];
      write_one(VEC[v][31:16], VEC[v][15:8], ok);
      chk("R4 write acks", {31'd0, ok}, 32'd1);
      rand_read(VEC[v][31:16], d);
      chk("R5 R6 readback", {24'd0, d}, {24'd0, VEC[v][7:0]});
    end
    wp = 1'b0;

    // R8 busy window
    addr_phase(16'h0100, ok); send_byte(8'h42, k); bus_stop;
    addr_phase(16'h0100, ok); send_byte(8'h24, k); bus_stop;
    chk("R8 nack while busy", {31'd0, ok}, 32'd0);
    wait_ready;
    rand_read(16'h0100, d);
    chk("R8 no change while busy", {24'd0, d}, 32'h42);

    // R7 page wrap, partial page
    addr_phase(16'h001E, ok);
    send_byte(8'hD0, k); send_byte(8'hD1, k); send_byte(8'hD2, k); send_byte(8'hD3, k);
    bus_stop; wait_ready;
    rand_read(16'h001E, d); chk("R7 page byte 0x1E", {24'd0, d}, 32'hD0);
    rand_read(16'h001F, d); chk("R7 page byte 0x1F", {24'd0, d}, 32'hD1);
    rand_read(16'h0000, d); chk("R7 wrapped to 0x00", {24'd0, d}, 32'hD2);
    rand_read(16'h0001, d); chk("R7 wrapped to 0x01", {24'd0, d}, 32'hD3);

    // R9 sequential read wraps at top
    addr_phase(16'h1FFF, ok);
    bus_start; send_byte(CR, k); recv_byte(d, 1'b1); recv_byte(d2, 1'b0); bus_stop;
    chk("R9 seq byte at 0x1FFF", {24'd0, d}, 32'hC3);
    chk("R9 seq wrap to 0x0000", {24'd0, d2}, 32'hD2);

    // R10 current address read
    bus_start; send_byte(CR, k); recv_byte(d, 1'b0); bus_stop;
    chk("R10 current address read", {24'd0, d}, 32'hD3);

    // R2 data byte cut by a repeated start
    addr_phase(16'h0005, ok);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; hp; scl_m = 1'b1; hp; scl_m = 1'b0; hp;
    end
    bus_start; send_byte(CR, k); recv_byte(d, 1'b0); bus_stop;
    chk("R2 aborted byte not stored", {24'd0, d}, 32'h99);
    bus_start; send_byte(CW, k); bus_stop;
    chk("R2 abort starts no busy", {31'd0, k}, 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule